// File: doc/BRIEF.md
# Condition Code Branch Evaluator

This block decides whether a conditional register move or a conditional jump takes effect. It keeps three one-bit status flags: zero, negative and signed overflow. The flags are written only when the arithmetic unit raises its flag-write strobe. A 4-bit condition selector is decoded against the stored flags into a single "take it" bit.

The same selector table serves both moves and jumps. Selector 0 means "always", so a plain register copy and an unconditional jump are just the always-true case. Selectors 1 to 6 compare the stored flags as a signed result. Selectors 7 to 15 are not defined: they never yield a true condition and they raise an invalid-selector output.

The condition bit is a combinational function of the selector and the registered flags. A flag write therefore becomes visible to condition evaluation one cycle after its strobe.

Top module: `cc_branch_eval`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets the stored flags to zero=1, negative=0, overflow=0. After reset, selector 3 is true, selector 4 is false, selector 2 is false and selector 1 is true.
- R2: When `flag_wr` is high at a rising edge, the stored flags take the values of `zero_in`, `neg_in` and `ovf_in`.
- R3: When `flag_wr` is low at a rising edge, the stored flags keep their values, whatever `zero_in`, `neg_in` and `ovf_in` carry.
- R4: Selector 0 gives `cond_ok`=1 for every flag state.
- R5: Selector 2 (less) gives negative XOR overflow. Selector 1 (less-or-equal) gives that value OR zero.
- R6: Selector 3 (equal) gives the zero flag. Selector 4 (not equal) gives its inverse.
- R7: Selector 5 (greater-or-equal) gives NOT(negative XOR overflow). Selector 6 (greater) gives NOT((negative XOR overflow) OR zero).
- R8: In the cycle that `flag_wr` is high, `cond_ok` is still computed from the previously stored flags. The new flags are used from the cycle after the edge.
- R9: Selectors 7 to 15 give `cond_ok`=0 and `bad_code`=1. Selectors 0 to 6 give `bad_code`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flag_wr | input | 1 | Flag-write strobe from the arithmetic unit |
| zero_in | input | 1 | New zero flag (result equals zero) |
| neg_in | input | 1 | New negative flag (result sign bit) |
| ovf_in | input | 1 | New signed-overflow flag |
| func_code | input | 4 | Condition selector, 0 to 6 defined |
| cond_ok | output | 1 | Condition holds, so the move or jump takes effect |
| bad_code | output | 1 | Selector lies outside 0 to 6 |

## Verification
The clocked properties assume that `func_code` and `flag_wr` are known (never X or Z) at every rising edge outside reset. They also assume the flag inputs are stable at the edge where `flag_wr` is high. The bench drives every input at the falling edge and sets each one at time zero, before the first rising edge. It holds `rst` high from time zero, so no property sees undriven values.

// File: rtl/ccb_pkg.sv
package ccb_pkg;

    localparam int FN_W      = 4;
    localparam int NUM_CODES = 7;

    typedef enum logic [FN_W-1:0] {
        SEL_ALWAYS = 4'd0,
        SEL_LE     = 4'd1,
        SEL_LT     = 4'd2,
        SEL_EQ     = 4'd3,
        SEL_NE     = 4'd4,
        SEL_GE     = 4'd5,
        SEL_GT     = 4'd6
    } sel_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{zero: 1'b1, neg: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/ccb_flag_reg.sv
module ccb_flag_reg
    import ccb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr,
    input  flags_t flags_in,
    output flags_t flags_q
);

    flags_t st_d;
    flags_t st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = FLAGS_RESET;
        end else if (wr) begin
            st_d = flags_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flags_q = st_q;

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr |=> (st_q == $past(flags_in)));                          // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(st_q));                                      // R3

endmodule

// File: rtl/ccb_cond_decode.sv
module ccb_cond_decode
    import ccb_pkg::*;
(
    input  logic [FN_W-1:0] sel,
    input  flags_t          flags,
    output logic            take,
    output logic            invalid
);

    logic less_w;
    logic less_eq_w;

    assign less_w    = flags.neg ^ flags.ovf;
    assign less_eq_w = less_w | flags.zero;

    always_comb begin
        take    = 1'b0;
        invalid = 1'b0;
        case (sel)
            SEL_ALWAYS: take = 1'b1;
            SEL_LE:     take = less_eq_w;
            SEL_LT:     take = less_w;
            SEL_EQ:     take = flags.zero;
            SEL_NE:     take = ~flags.zero;
            SEL_GE:     take = ~less_w;
            SEL_GT:     take = ~less_eq_w;
            default:    invalid = 1'b1;
        endcase
    end

endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
    import ccb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flag_wr,
    input  logic            zero_in,
    input  logic            neg_in,
    input  logic            ovf_in,
    input  logic [FN_W-1:0] func_code,
    output logic            cond_ok,
    output logic            bad_code
);

    localparam logic [FN_W-1:0] FN_LIMIT = FN_W'(NUM_CODES);

    flags_t new_flags;
    flags_t cur_flags;

    assign new_flags = '{zero: zero_in, neg: neg_in, ovf: ovf_in};

    ccb_flag_reg u_flags (
        .clk      (clk),
        .rst      (rst),
        .wr       (flag_wr),
        .flags_in (new_flags),
        .flags_q  (cur_flags)
    );

    ccb_cond_decode u_decode (
        .sel     (func_code),
        .flags   (cur_flags),
        .take    (cond_ok),
        .invalid (bad_code)
    );

    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (func_code == '0) |-> cond_ok);                              // R4
    AST_BAD_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (func_code >= FN_LIMIT) |-> (bad_code && !cond_ok));         // R9
    AST_GOOD_NOT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (func_code < FN_LIMIT) |-> !bad_code);                       // R9
    AST_EQ_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && zero_in) |=> ((func_code != FN_W'(3)) || cond_ok)); // R2

endmodule

// File: tb/cc_branch_eval_bench.sv
module cc_branch_eval_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flag_wr = 1'b0;
    logic       zero_in = 1'b0;
    logic       neg_in = 1'b0;
    logic       ovf_in = 1'b0;
    logic [3:0] func_code = 4'd0;
    logic       cond_ok;
    logic       bad_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit m_z = 1'b1, m_s = 1'b0, m_o = 1'b0;

    always #5 clk = ~clk;

    cc_branch_eval u_cc_branch_eval (
        .clk(clk), .rst(rst), .flag_wr(flag_wr),
        .zero_in(zero_in), .neg_in(neg_in), .ovf_in(ovf_in),
        .func_code(func_code), .cond_ok(cond_ok), .bad_code(bad_code)
    );

    function automatic bit exp_cond(input int fn, input bit z, input bit s, input bit o);
        bit lt;
        lt = s ^ o;
        case (fn)
            0: return 1'b1;
            1: return lt | z;
            2: return lt;
            3: return z;
            4: return !z;
            5: return !lt;
            6: return !(lt | z);
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input int fn, input bit got, input bit exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s code=%0d actual=%0b expected=%0b", req, fn, got, exp);
        end
    endtask

    // drive selector at falling edge, sample 1 ns later
    task automatic eval_code(input string req, input int fn);
        @(negedge clk);
        func_code = 4'(fn);
        #1;
        check(req, fn, cond_ok, exp_cond(fn, m_z, m_s, m_o));
        check({req, "_bad"}, fn, bad_code, (fn > 6));
    endtask

    task automatic sweep_defined(input string req);
        for (int fn = 0; fn < 7; fn++) eval_code(req, fn);
    endtask

    task automatic load_flags(input bit z, input bit s, input bit o);
        @(negedge clk);
        flag_wr = 1'b1; zero_in = z; neg_in = s; ovf_in = o;
        @(negedge clk);
        flag_wr = 1'b0;
        m_z = z; m_s = s; m_o = o;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_z = 1'b1; m_s = 1'b0; m_o = 1'b0;
        eval_code("R1", 3);
        eval_code("R1", 4);
        eval_code("R1", 2);
        eval_code("R1", 1);
    endtask

    task automatic t_patterns;
        for (int p = 0; p < 8; p++) begin
            load_flags(p[2], p[1], p[0]);
            eval_code("R2", 3);
            eval_code("R4", 0);
            eval_code("R5", 2);
            eval_code("R5", 1);
            eval_code("R6", 3);
            eval_code("R6", 4);
            eval_code("R7", 5);
            eval_code("R7", 6);
        end
    endtask

    task automatic t_hold;
        load_flags(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        flag_wr = 1'b0; zero_in = 1'b1; neg_in = 1'b0; ovf_in = 1'b0;
        repeat (2) @(negedge clk);
        sweep_defined("R3");
    endtask

    task automatic t_same_cycle;
        load_flags(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        func_code = 4'd3;
        flag_wr = 1'b1; zero_in = 1'b1; neg_in = 1'b1; ovf_in = 1'b0;
        #1;
        check("R8", 3, cond_ok, 1'b0);
        @(negedge clk);
        flag_wr = 1'b0;
        #1;
        check("R8", 3, cond_ok, 1'b1);
        m_z = 1'b1; m_s = 1'b1; m_o = 1'b0;
        eval_code("R8", 2);
    endtask

    task automatic t_invalid;
        load_flags(1'b1, 1'b1, 1'b0);
        for (int fn = 7; fn < 16; fn++) eval_code("R9", fn);
        eval_code("R9", 6);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_patterns();
        t_hold();
        t_same_cycle();
        t_invalid();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule